// File: doc/BRIEF.md
# Asynchronous External Memory Access Timing Generator

This block runs single accesses to an asynchronous, non-multiplexed external memory with a 16-bit data bus. A request names one of eight chip selects, read or write, a word address, write data and byte selects. Each chip select has its own timing record on a flat configuration bus, so devices of different speeds can share the pins. Every strobe edge is a count of functional-clock cycles from the start of the access. Read data is sampled at a programmed point and returned with a one-cycle valid pulse.

Requests enter through a valid/ready handshake with a one-entry holding slot. A request that is waiting when an access finishes follows it at once. In that case a strobe that was low at the end of the first access and opens at count 0 in the second stays low, with no glitch. When idle insertion is enabled, the pins are instead held inactive for a programmed number of cycles. When an access ends with no request waiting, every strobe goes inactive, whatever its off time.

Top module: `extmem_timing_gen`

## Requirements
- R1: After reset every chip select, address valid, output enable, write enable and byte-enable pin is high, `rd_valid` is low and `req_ready` is high.
- R2: With the access counter at 0 in the first access cycle, a line is low exactly while on <= count < off, and an off time past the cycle end is cut at the cycle end. Only the requested chip-select pin moves. Output enable moves only on reads and write enable only on writes.
- R3: A read lasts the read cycle time and a write lasts the write cycle time; a value of 0 counts as 1. Address and byte enables (`mem_be_n` = inverse of `req_be`) hold for the whole access. An access from idle starts in the cycle after the accepting clock edge.
- R4: In any cycle outside an access all control pins are high, so an access ending with nothing pending leaves all of them high in the next cycle.
- R5: With no idle insertion, a pending access starts in the cycle right after the last cycle of the current one. A line low in that last cycle whose on time in the next access is 0 stays low, and a line whose next on time is above 0 goes high.
- R6: Idle insertion follows the finished access's chip select record. The same-select enable applies when the next chip select matches and the other-select enable applies when it differs. When the applicable enable is 1, all pins stay high for the idle count cycles before the next access.
- R7: On a read, `mem_din` is registered at the end of the cycle whose count equals the read access time, clipped to the last cycle of the access. `rd_data` shows it with `rd_valid` high for the next cycle only. Writes give no pulse.
- R8: `req_ready` is high when the slot is empty or when the slot empties at the coming edge. A request behind a running access is therefore accepted at that access's first edge, and the next one at its last edge.
- R9: Chip select i uses bits [62i+61:62i] of `cfg_bus`, LSB first: read cycle [4:0], write cycle [9:5], select on [14:10], select off [19:15], address-valid on [24:20], address-valid off [29:25], output-enable on [34:30], output-enable off [39:35], write-enable on [44:40], write-enable off [49:45], read access [54:50], idle count [59:55], same-select idle enable [60], other-select idle enable [61].
- R10: During a write, `mem_dout` carries the write data and `mem_doe` is high. Outside writes `mem_doe` is low.

Ports:
## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_bus | input | 496 | Timing records of all chip selects |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_cs | input | 3 | Target chip select |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte selects, active high |
| mem_cs_n | output | 8 | Chip select pins, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | 2 | Byte enables, active low |
| mem_addr | output | 10 | Address pins |
| mem_dout | output | 16 | Write data to the device |
| mem_doe | output | 1 | Data bus drive enable |
| mem_din | input | 16 | Read data from the device |
| rd_valid | output | 1 | One-cycle read return pulse |
| rd_data | output | 16 | Returned read data |

## Verification
A wrong access counter or phase shows at the pins within one cycle, as a strobe edge in the wrong place or pins left low after the cycle should end. A wrong holding-slot state shows as `req_ready` at the wrong level, or as the second access of a pair starting early, late or with a spurious idle gap. A wrong sampling point returns the idle-bus pattern or a pulse at the wrong cycle, one cycle after the access time. The checks compare complete per-cycle traces of the pins with a timing model written from the requirements.

// File: rtl/extmem_pkg.sv
package extmem_pkg;

  localparam int TW = 5;

  // per chip select timing record; field order fixes the cfg_bus layout
  typedef struct packed {
    logic          en_diff;
    logic          en_same;
    logic [TW-1:0] idle_len;
    logic [TW-1:0] rd_acc;
    logic [TW-1:0] we_off;
    logic [TW-1:0] we_on;
    logic [TW-1:0] oe_off;
    logic [TW-1:0] oe_on;
    logic [TW-1:0] adv_off;
    logic [TW-1:0] adv_on;
    logic [TW-1:0] cs_off;
    logic [TW-1:0] cs_on;
    logic [TW-1:0] wr_cyc;
    logic [TW-1:0] rd_cyc;
  } cs_cfg_t;

  localparam int CFG_W = $bits(cs_cfg_t);

  typedef enum logic {PH_IDLE, PH_ACC} phase_t;

  // last counter value of an access; zero length treated as one cycle
  function automatic logic [TW-1:0] cycle_last(cs_cfg_t c, logic we);
    logic [TW-1:0] len;
    len = we ? c.wr_cyc : c.rd_cyc;
    return (len == '0) ? '0 : len - 1'b1;
  endfunction

  function automatic logic in_window(logic [TW-1:0] cnt, logic [TW-1:0] on,
                                     logic [TW-1:0] off);
    return (cnt >= on) && (cnt < off);
  endfunction

  function automatic logic [TW-1:0] sample_point(cs_cfg_t c);
    logic [TW-1:0] last;
    last = cycle_last(c, 1'b0);
    return (c.rd_acc > last) ? last : c.rd_acc;
  endfunction

  function automatic logic [TW-1:0] gap_need(cs_cfg_t c, logic same);
    logic en;
    en = same ? c.en_same : c.en_diff;
    return en ? c.idle_len : '0;
  endfunction

endpackage

// File: rtl/extmem_cfg_select.sv
module extmem_cfg_select
  import extmem_pkg::*;
#(
  parameter int NCS = 8,
  localparam int CSW = $clog2(NCS)
) (
  input  logic [NCS*CFG_W-1:0] cfg_bus,
  input  logic [CSW-1:0]       sel,
  output cs_cfg_t              cfg
);

  cs_cfg_t recs [NCS];

  for (genvar gi = 0; gi < NCS; gi++) begin : g_unpack
    assign recs[gi] = cs_cfg_t'(cfg_bus[gi*CFG_W +: CFG_W]);
  end

  assign cfg = recs[sel];

endmodule

// File: rtl/extmem_line_decode.sv
module extmem_line_decode
  import extmem_pkg::*;
#(
  parameter int NCS = 8,
  parameter int BW  = 2,
  localparam int CSW = $clog2(NCS)
) (
  input  logic           active,
  input  logic [TW-1:0]  cnt,
  input  cs_cfg_t        cfg,
  input  logic [CSW-1:0] cs,
  input  logic           we,
  input  logic [BW-1:0]  be,
  output logic [NCS-1:0] cs_n,
  output logic           adv_n,
  output logic           oe_n,
  output logic           we_n,
  output logic [BW-1:0]  be_n
);

  logic cs_win;
  assign cs_win = active && in_window(cnt, cfg.cs_on, cfg.cs_off);

  for (genvar gi = 0; gi < NCS; gi++) begin : g_cs
    assign cs_n[gi] = !(cs_win && (cs == CSW'(gi)));
  end

  assign adv_n = !(active && in_window(cnt, cfg.adv_on, cfg.adv_off));
  assign oe_n  = !(active && !we && in_window(cnt, cfg.oe_on, cfg.oe_off));
  assign we_n  = !(active && we && in_window(cnt, cfg.we_on, cfg.we_off));
  assign be_n  = active ? ~be : {BW{1'b1}};

endmodule

// File: rtl/extmem_seq.sv
module extmem_seq
  import extmem_pkg::*;
#(
  parameter int NCS = 8,
  parameter int AW  = 10,
  parameter int DW  = 16,
  localparam int CSW = $clog2(NCS),
  localparam int BW  = DW / 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [CSW-1:0] req_cs,
  input  logic           req_we,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  logic [BW-1:0]  req_be,
  input  cs_cfg_t        cur_cfg,
  output phase_t         st_q,
  output logic [TW-1:0]  cnt_q,
  output logic [CSW-1:0] cs_q,
  output logic           we_q,
  output phase_t         st_d,
  output logic [TW-1:0]  cnt_d,
  output logic [CSW-1:0] cs_d,
  output logic           we_d,
  output logic [AW-1:0]  addr_d,
  output logic [DW-1:0]  wdata_d,
  output logic [BW-1:0]  be_d,
  output logic           launch,
  output logic           acc_last
);

  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q;
  logic [BW-1:0]  be_q;
  logic [TW-1:0]  quiet_q, quiet_d;

  logic           pend_valid;
  logic [CSW-1:0] pend_cs;
  logic           pend_we;
  logic [AW-1:0]  pend_addr;
  logic [DW-1:0]  pend_wdata;
  logic [BW-1:0]  pend_be;

  logic [TW-1:0]  need;
  logic           accept;

  assign acc_last  = (st_q == PH_ACC) && (cnt_q == cycle_last(cur_cfg, we_q));
  assign need      = gap_need(cur_cfg, pend_cs == cs_q);
  assign launch    = pend_valid &&
                     (((st_q == PH_ACC) && acc_last && (need == '0)) ||
                      ((st_q == PH_IDLE) && (quiet_q >= need)));
  assign req_ready = !pend_valid || launch;
  assign accept    = req_valid && req_ready;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    cs_d    = cs_q;
    we_d    = we_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    be_d    = be_q;
    quiet_d = quiet_q;
    if (launch) begin
      st_d    = PH_ACC;
      cnt_d   = '0;
      cs_d    = pend_cs;
      we_d    = pend_we;
      addr_d  = pend_addr;
      wdata_d = pend_wdata;
      be_d    = pend_be;
    end else if (st_q == PH_ACC) begin
      if (acc_last) begin
        st_d    = PH_IDLE;
        quiet_d = TW'(1);
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (quiet_q != {TW{1'b1}}) begin
      quiet_d = quiet_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PH_IDLE;
      cnt_q   <= '0;
      cs_q    <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      quiet_q <= {TW{1'b1}};
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      cs_q    <= cs_d;
      we_q    <= we_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      be_q    <= be_d;
      quiet_q <= quiet_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_cs    <= '0;
      pend_we    <= 1'b0;
      pend_addr  <= '0;
      pend_wdata <= '0;
      pend_be    <= '0;
    end else if (accept) begin
      pend_valid <= 1'b1;
      pend_cs    <= req_cs;
      pend_we    <= req_we;
      pend_addr  <= req_addr;
      pend_wdata <= req_wdata;
      pend_be    <= req_be;
    end else if (launch) begin
      pend_valid <= 1'b0;
    end
  end

  // R8: every access start is fed from the holding slot
  assert_start_from_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_ACC && cnt_q == '0) |-> $past(pend_valid));

endmodule

// File: rtl/extmem_timing_gen.sv
module extmem_timing_gen
  import extmem_pkg::*;
#(
  parameter int NCS = 8,
  parameter int AW  = 10,
  parameter int DW  = 16,
  localparam int CSW = $clog2(NCS),
  localparam int BW  = DW / 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCS*CFG_W-1:0] cfg_bus,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [CSW-1:0]       req_cs,
  input  logic                 req_we,
  input  logic [AW-1:0]        req_addr,
  input  logic [DW-1:0]        req_wdata,
  input  logic [BW-1:0]        req_be,
  output logic [NCS-1:0]       mem_cs_n,
  output logic                 mem_adv_n,
  output logic                 mem_oe_n,
  output logic                 mem_we_n,
  output logic [BW-1:0]        mem_be_n,
  output logic [AW-1:0]        mem_addr,
  output logic [DW-1:0]        mem_dout,
  output logic                 mem_doe,
  input  logic [DW-1:0]        mem_din,
  output logic                 rd_valid,
  output logic [DW-1:0]        rd_data
);

  phase_t         st_q, st_d;
  logic [TW-1:0]  cnt_q, cnt_d;
  logic [CSW-1:0] cs_q, cs_d;
  logic           we_q, we_d;
  logic [AW-1:0]  addr_d;
  logic [DW-1:0]  wdata_d;
  logic [BW-1:0]  be_d;
  logic           launch, acc_last;
  cs_cfg_t        cur_cfg, nxt_cfg;

  logic [NCS-1:0] dec_cs_n;
  logic           dec_adv_n, dec_oe_n, dec_we_n;
  logic [BW-1:0]  dec_be_n;
  logic           sample_now;

  extmem_cfg_select #(.NCS(NCS)) u_cur_cfg (
    .cfg_bus(cfg_bus), .sel(cs_q), .cfg(cur_cfg));

  extmem_cfg_select #(.NCS(NCS)) u_nxt_cfg (
    .cfg_bus(cfg_bus), .sel(cs_d), .cfg(nxt_cfg));

  extmem_seq #(.NCS(NCS), .AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_cs(req_cs),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .cur_cfg(cur_cfg),
    .st_q(st_q), .cnt_q(cnt_q), .cs_q(cs_q), .we_q(we_q),
    .st_d(st_d), .cnt_d(cnt_d), .cs_d(cs_d), .we_d(we_d),
    .addr_d(addr_d), .wdata_d(wdata_d), .be_d(be_d),
    .launch(launch), .acc_last(acc_last));

  // decode the coming state so pins leave flops with no decode glitch
  extmem_line_decode #(.NCS(NCS), .BW(BW)) u_dec (
    .active(st_d == PH_ACC), .cnt(cnt_d), .cfg(nxt_cfg), .cs(cs_d),
    .we(we_d), .be(be_d),
    .cs_n(dec_cs_n), .adv_n(dec_adv_n), .oe_n(dec_oe_n), .we_n(dec_we_n),
    .be_n(dec_be_n));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_cs_n  <= {NCS{1'b1}};
      mem_adv_n <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_be_n  <= {BW{1'b1}};
      mem_addr  <= '0;
      mem_dout  <= '0;
      mem_doe   <= 1'b0;
    end else begin
      mem_cs_n  <= dec_cs_n;
      mem_adv_n <= dec_adv_n;
      mem_oe_n  <= dec_oe_n;
      mem_we_n  <= dec_we_n;
      mem_be_n  <= dec_be_n;
      mem_addr  <= addr_d;
      mem_dout  <= wdata_d;
      mem_doe   <= (st_d == PH_ACC) && we_d;
    end
  end

  assign sample_now = (st_q == PH_ACC) && !we_q && (cnt_q == sample_point(cur_cfg));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= sample_now;
      if (sample_now) rd_data <= mem_din;
    end
  end

  // R4: pins inactive whenever no access is running
  assert_idle_pins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_IDLE) |-> (&mem_cs_n && mem_adv_n && mem_oe_n && mem_we_n && &mem_be_n));

  // R3: address and byte enables hold through an access
  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_ACC && cnt_q != '0) |-> ($stable(mem_addr) && $stable(mem_be_n)));

  // R2: output enable and write enable never low together
  assert_oe_we_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_oe_n || mem_we_n));

  // R9: at most one chip select pin low
  assert_one_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));

  // R7: a return pulse follows a read cycle
  assert_rvalid_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(st_q == PH_ACC && !we_q));

endmodule

// File: tb/extmem_timing_gen_bench.sv
module extmem_timing_gen_bench;

  localparam int CW = 62;
  localparam int TL = 1024;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [8*CW-1:0] cfg_bus = '0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [2:0]      req_cs = '0;
  logic            req_we = 1'b0;
  logic [9:0]      req_addr = '0;
  logic [15:0]     req_wdata = '0;
  logic [1:0]      req_be = '0;
  logic [7:0]      mem_cs_n;
  logic            mem_adv_n, mem_oe_n, mem_we_n, mem_doe;
  logic [1:0]      mem_be_n;
  logic [9:0]      mem_addr;
  logic [15:0]     mem_dout, mem_din, rd_data;
  logic            rd_valid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [CW-1:0] cfgv [8];

  logic [7:0]  t_cs   [TL];
  logic [3:0]  t_ctl  [TL];  // {adv,oe,we,doe}
  logic [1:0]  t_be   [TL];
  logic [9:0]  t_addr [TL];
  logic [15:0] t_dout [TL];
  int          rv_idx = -1;
  logic [15:0] rv_data = '0;

  always #2 clk = ~clk;

  extmem_timing_gen u_extmem_timing_gen (
    .clk(clk), .rst_n(rst_n), .cfg_bus(cfg_bus),
    .req_valid(req_valid), .req_ready(req_ready), .req_cs(req_cs),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_be_n(mem_be_n),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_doe(mem_doe),
    .mem_din(mem_din), .rd_valid(rd_valid), .rd_data(rd_data));

  function automatic logic [15:0] pattern(logic [9:0] a);
    return {6'h2A, a} ^ 16'h1357;
  endfunction

  // device model: drives data only while output enable is low
  assign mem_din = !mem_oe_n ? pattern(mem_addr) : 16'hFFFF;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    t_cs[cyc % TL]   = mem_cs_n;
    t_ctl[cyc % TL]  = {mem_adv_n, mem_oe_n, mem_we_n, mem_doe};
    t_be[cyc % TL]   = mem_be_n;
    t_addr[cyc % TL] = mem_addr;
    t_dout[cyc % TL] = mem_dout;
    if (rd_valid) begin
      rv_idx  = cyc;
      rv_data = rd_data;
    end
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] mk_cfg(int rdc, int wrc, int cson, int csoff,
      int advon, int advoff, int oeon, int oeoff, int weon, int weoff,
      int racc, int idl, bit es, bit ed);
    logic [CW-1:0] v = '0;
    v[4:0] = rdc[4:0];     v[9:5] = wrc[4:0];
    v[14:10] = cson[4:0];  v[19:15] = csoff[4:0];
    v[24:20] = advon[4:0]; v[29:25] = advoff[4:0];
    v[34:30] = oeon[4:0];  v[39:35] = oeoff[4:0];
    v[44:40] = weon[4:0];  v[49:45] = weoff[4:0];
    v[54:50] = racc[4:0];  v[59:55] = idl[4:0];
    v[60] = es;            v[61] = ed;
    return v;
  endfunction

  task automatic set_cfg(int cs, logic [CW-1:0] v);
    cfgv[cs] = v;
    cfg_bus[cs*CW +: CW] = v;
  endtask

  function automatic int acc_len(int cs, bit we);
    int l = we ? int'(cfgv[cs][9:5]) : int'(cfgv[cs][4:0]);
    return (l == 0) ? 1 : l;
  endfunction

  // called at a falling edge; returns the trace index right after acceptance
  task automatic issue(int cs, bit we, int addr, int wd, logic [1:0] be,
                       output int acc);
    req_valid = 1'b1;
    req_cs = cs[2:0]; req_we = we; req_addr = addr[9:0];
    req_wdata = wd[15:0]; req_be = be;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    acc = cyc;
    req_valid = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // full per-cycle pin comparison of one access against the timing model
  task automatic check_access(int st, int cs, bit we, int addr, int wd,
                              logic [1:0] be, string req);
    logic [CW-1:0] c = cfgv[cs];
    int len = acc_len(cs, we);
    bit ok = 1'b1;
    longint a_bad = 0, e_bad = 0;
    bit ok_d = 1'b1;
    for (int k = 0; k < len; k++) begin
      int i = (st + k) % TL;
      logic [7:0] ecs = 8'hFF;
      logic eadv, eoe, ewe;
      logic [24:0] av, ev;
      if (k >= c[14:10] && k < c[19:15]) ecs[cs] = 1'b0;
      eadv = !(k >= c[24:20] && k < c[29:25]);
      eoe  = we ? 1'b1 : !(k >= c[34:30] && k < c[39:35]);
      ewe  = we ? !(k >= c[44:40] && k < c[49:45]) : 1'b1;
      av = {t_cs[i], t_ctl[i][3:1], t_be[i], t_addr[i], t_ctl[i][0], 1'b0};
      ev = {ecs, eadv, eoe, ewe, ~be, addr[9:0], we, 1'b0};
      if (av !== ev && ok) begin
        ok = 1'b0; a_bad = longint'(av); e_bad = longint'(ev);
      end
      if (we && t_dout[i] !== wd[15:0]) ok_d = 1'b0;
    end
    chk(ok, {req, " pins R2 R3 R9"}, a_bad, e_bad);
    if (we) chk(ok_d, {req, " write data R10"}, t_dout[st % TL], wd);
  endtask

  task automatic check_idle(int i, string req);
    logic [13:0] av = {t_cs[i % TL], t_ctl[i % TL][3:1], t_be[i % TL], t_ctl[i % TL][0]};
    chk(av === 14'h3FFE, req, av, 14'h3FFE);
  endtask

  task automatic t_reset;
    chk({mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n, mem_be_n} === 13'h1FFF,
        "R1 pins after reset", {mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n, mem_be_n}, 13'h1FFF);
    chk(rd_valid === 1'b0, "R1 rd_valid", rd_valid, 0);
    chk(req_ready === 1'b1, "R1 req_ready", req_ready, 1);
  endtask

  task automatic t_single_read;
    int acc, st;
    rv_idx = -1;
    issue(2, 0, 10'h155, 0, 2'b11, acc);
    st = acc + 1;
    wait_cyc(12);
    check_access(st, 2, 0, 10'h155, 0, 2'b11, "single read");
    check_idle(st + 8, "R4 idle after read");
    chk(rv_idx == st + 7, "R7 rd_valid cycle", rv_idx, st + 7);
    chk(rv_data === pattern(10'h155), "R7 rd_data", rv_data, pattern(10'h155));
  endtask

  task automatic t_single_write;
    int acc, st;
    rv_idx = -1;
    issue(5, 1, 10'h0A3, 16'hBEEF, 2'b01, acc);
    st = acc + 1;
    wait_cyc(10);
    check_access(st, 5, 1, 10'h0A3, 16'hBEEF, 2'b01, "single write");
    check_idle(st + 6, "R4 idle after write");
    chk(rv_idx == -1, "R7 no pulse on write", rv_idx, -1);
  endtask

  task automatic t_pipelined;
    int acc_a, acc_b, st_a, st_b;
    issue(1, 0, 10'h010, 0, 2'b11, acc_a);
    issue(1, 1, 10'h011, 16'h1234, 2'b11, acc_b);
    st_a = acc_a + 1;
    st_b = st_a + 4;
    chk(acc_b == st_a, "R8 second request accepted at first launch", acc_b, st_a);
    wait_cyc(10);
    check_access(st_a, 1, 0, 10'h010, 0, 2'b11, "R5 first");
    check_access(st_b, 1, 1, 10'h011, 16'h1234, 2'b11, "R5 second");
    chk(t_cs[(st_b - 1) % TL][1] === 1'b0 && t_cs[st_b % TL][1] === 1'b0,
        "R5 select held across boundary", t_cs[st_b % TL], 8'hFD);
    chk(t_ctl[(st_b - 1) % TL][2] === 1'b0 && t_ctl[st_b % TL][2] === 1'b1,
        "R5 output enable released", t_ctl[st_b % TL][2], 1);
  endtask

  task automatic t_same_gap;
    int acc_a, acc_b, st_a, st_b;
    issue(1, 0, 10'h020, 0, 2'b10, acc_a);
    issue(1, 0, 10'h021, 0, 2'b10, acc_b);
    st_a = acc_a + 1;
    st_b = st_a + 4 + 3;
    wait_cyc(14);
    check_access(st_a, 1, 0, 10'h020, 0, 2'b10, "R6 same first");
    for (int g = 0; g < 3; g++) check_idle(st_a + 4 + g, "R6 same-select gap");
    check_access(st_b, 1, 0, 10'h021, 0, 2'b10, "R6 same second");
  endtask

  task automatic t_diff_gap;
    int acc_a, acc_b, st_a, st_b;
    // cs1 has other-select idle enabled with count 3
    issue(1, 0, 10'h030, 0, 2'b11, acc_a);
    issue(2, 0, 10'h031, 0, 2'b11, acc_b);
    st_a = acc_a + 1;
    st_b = st_a + 4 + 3;
    wait_cyc(18);
    for (int g = 0; g < 3; g++) check_idle(st_a + 4 + g, "R6 other-select gap");
    check_access(st_b, 2, 0, 10'h031, 0, 2'b11, "R6 other second");
    // cs2 has both enables off: no gap toward cs1
    issue(2, 0, 10'h040, 0, 2'b11, acc_a);
    issue(1, 1, 10'h041, 16'h5AA5, 2'b11, acc_b);
    st_a = acc_a + 1;
    st_b = st_a + 8;
    wait_cyc(16);
    check_access(st_b, 1, 1, 10'h041, 16'h5AA5, 2'b11, "R6 no gap when disabled");
  endtask

  task automatic t_sample_clip;
    int acc, st;
    rv_idx = -1;
    issue(3, 0, 10'h2C7, 0, 2'b11, acc);
    st = acc + 1;
    wait_cyc(8);
    chk(rv_idx == st + 4, "R7 sample clipped to last cycle", rv_idx, st + 4);
    chk(rv_data === pattern(10'h2C7), "R7 clipped data", rv_data, pattern(10'h2C7));
    issue(3, 1, 10'h001, 16'hCAFE, 2'b11, acc);
    st = acc + 1;
    wait_cyc(4);
    check_access(st, 3, 1, 10'h001, 16'hCAFE, 2'b11, "R3 zero cycle as one");
    check_idle(st + 1, "R3 R4 one-cycle write ends");
  endtask

  task automatic t_handshake;
    int acc_a, acc_b, acc_c, st_a;
    issue(4, 0, 10'h050, 0, 2'b11, acc_a);
    issue(4, 0, 10'h051, 0, 2'b11, acc_b);
    st_a = acc_a + 1;
    chk(req_ready === 1'b0, "R8 ready low with slot full", req_ready, 0);
    issue(4, 0, 10'h052, 0, 2'b11, acc_c);
    chk(acc_c == st_a + 4, "R8 third accepted at first end", acc_c, st_a + 4);
    wait_cyc(14);
    check_access(st_a + 8, 4, 0, 10'h052, 0, 2'b11, "R8 third access");
  endtask

  initial begin
    set_cfg(1, mk_cfg(4, 4, 0, 31, 0, 1, 0, 31, 0, 31, 3, 3, 1'b0, 1'b1));
    set_cfg(2, mk_cfg(8, 6, 0, 7, 1, 3, 2, 7, 1, 5, 6, 0, 1'b0, 1'b0));
    set_cfg(3, mk_cfg(4, 0, 0, 31, 0, 1, 0, 31, 0, 1, 20, 0, 1'b0, 1'b0));
    set_cfg(4, mk_cfg(4, 4, 1, 4, 0, 2, 1, 4, 1, 3, 2, 0, 1'b0, 1'b1));
    set_cfg(5, mk_cfg(8, 6, 0, 6, 0, 2, 1, 5, 1, 5, 4, 0, 1'b0, 1'b0));
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_single_read();
    t_single_write();
    t_pipelined();
    set_cfg(1, mk_cfg(4, 4, 0, 31, 0, 1, 0, 31, 0, 31, 3, 3, 1'b1, 1'b1));
    t_same_gap();
    t_diff_gap();
    t_sample_clip();
    t_handshake();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule